// File: doc/BRIEF.md
# Halt-Mode Sleep and Wake Sequencer

This block puts a small 8-bit controller to sleep when the core decodes a HALT instruction, and brings it back. From the running state a HALT strobe has one of three outcomes. If the active-halt configuration is selected, the strobe is not handled here. If the watchdog is running and its keep-alive-in-halt option is clear, the strobe becomes a watchdog reset request. Otherwise the block stops the main oscillator and gates the CPU and internal peripheral clocks. On entry it also clears the interrupt mask bit, so that interrupts can wake the chip.

While halted, only two things end the sleep: an interrupt line that the wake mask marks as wake-capable, or a reset wake event. The oscillator restarts at once. The clocks then stay gated for a fixed settling window of `SETTLE_CYCLES` oscillator cycles. After that the block returns to the running state and pulses a resume strobe for one cycle. A tag on the strobe tells the core whether to service the waking interrupt or to fetch the reset vector. Peripherals clocked from an auxiliary source are outside this block and are not gated.

Top module: `halt_wake_seq`

## Requirements
- R1: A `halt_req` pulse while `active_halt_en` is 1 is ignored. The block stays running with `osc_en`=1 and `cpu_clk_en`=1, and it asserts neither `imask_clr` nor `wdg_rst_req`.
- R2: Suppose `halt_req` arrives while running with `active_halt_en`=0, `wdg_en`=1 and `wdg_halt_opt`=0. In the next cycle `wdg_rst_req` is 1, `osc_en` stays 1 and `cpu_clk_en` is 0. One cycle later `wdg_rst_req` is 0 and the block runs again.
- R3: Suppose `halt_req` arrives while running with `active_halt_en`=0, and either `wdg_en`=0 or `wdg_halt_opt`=1. In the next cycle `osc_en`=0 and `cpu_clk_en`=0, and `imask_clr` is 1 for exactly that one cycle.
- R4: While halted, interrupt lines whose `irq_wake_mask` bit is 0 have no effect: `osc_en` stays 0.
- R5: If a wake-capable interrupt (`irq_req & irq_wake_mask` nonzero) is already pending when HALT is entered, the halted state lasts exactly one cycle and `osc_en` returns to 1 in the following cycle.
- R6: `osc_en` returns to 1 in the cycle after a wake event is seen. `cpu_clk_en` then stays 0 for exactly `SETTLE_CYCLES` cycles (256 by default), counted from and including that cycle.
- R7: In the first running cycle after the settling window, `resume_stb` is 1 for one cycle with `cpu_clk_en`=1. For an interrupt wake, `resume_rst`=0, meaning service the interrupt.
- R8: A `wake_rst` wake gives `resume_rst`=1, meaning fetch the reset vector. When `wake_rst` and a wake-capable interrupt arrive in the same cycle, the reset wins.
- R9: After the asynchronous reset `rst_n`, the block is running: `osc_en`=1, `cpu_clk_en`=1, and `imask_clr`, `wdg_rst_req` and `resume_stb` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock (stops while halted except for this block's wake logic) |
| rst_n | input | 1 | Asynchronous active-low reset |
| halt_req | input | 1 | Decoded HALT instruction strobe |
| active_halt_en | input | 1 | Active-halt configuration selected (HALT not handled here) |
| wdg_en | input | 1 | Watchdog running |
| wdg_halt_opt | input | 1 | 1: HALT allowed with watchdog running; 0: HALT trips the watchdog |
| irq_req | input | NUM_IRQ | Interrupt request lines |
| irq_wake_mask | input | NUM_IRQ | 1 marks a line able to end HALT |
| wake_rst | input | 1 | Reset wake event while halted |
| osc_en | output | 1 | Main oscillator enable |
| cpu_clk_en | output | 1 | CPU and internal peripheral clock enable |
| imask_clr | output | 1 | Force-clear of the interrupt mask bit |
| wdg_rst_req | output | 1 | Watchdog reset request |
| resume_stb | output | 1 | One-cycle resume pulse |
| resume_rst | output | 1 | Resume tag: 1 reset-vector fetch, 0 interrupt service |

## Verification
The hardest situation to reach from the ports is the settling window's exact terminal cycle. A wake must first be accepted from a genuine halted state, and then the bench must count 256 gated cycles without missing or adding one. The bench enters HALT directly, wakes it, and counts the observed cycles with `cpu_clk_en` low until the resume strobe. It repeats this for interrupt, reset and simultaneous wakes, so that the count and the tag are checked against each other. The case of an interrupt pending at entry is reached by raising a wake-capable line before the HALT strobe.

// File: rtl/hws_pkg.sv
package hws_pkg;
  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_HALT   = 2'd1,
    ST_SETTLE = 2'd2,
    ST_WDGRST = 2'd3
  } hws_state_e;

  // HALT accepted: not the active-halt variant and watchdog does not object
  function automatic logic halt_allowed(input logic ah, input logic wen, input logic wopt);
    return !ah && (!wen || wopt);
  endfunction

  // HALT converted into a watchdog reset
  function automatic logic halt_trips_wdg(input logic ah, input logic wen, input logic wopt);
    return !ah && wen && !wopt;
  endfunction
endpackage

// File: rtl/hws_entry.sv
module hws_entry
  import hws_pkg::*;
(
  input  logic in_run,
  input  logic halt_req,
  input  logic active_halt_en,
  input  logic wdg_en,
  input  logic wdg_halt_opt,
  output logic halt_go,
  output logic wdg_trip
);
  always_comb begin
    halt_go  = in_run && halt_req && halt_allowed(active_halt_en, wdg_en, wdg_halt_opt);
    wdg_trip = in_run && halt_req && halt_trips_wdg(active_halt_en, wdg_en, wdg_halt_opt);
  end
endmodule

// File: rtl/hws_wake.sv
module hws_wake #(
  parameter int NUM_IRQ = 8
) (
  input  logic [NUM_IRQ-1:0] irq_req,
  input  logic [NUM_IRQ-1:0] irq_wake_mask,
  input  logic               wake_rst,
  output logic               wake_any,
  output logic               wake_by_rst
);
  function automatic logic masked_pending(input logic [NUM_IRQ-1:0] req,
                                          input logic [NUM_IRQ-1:0] msk);
    return |(req & msk);
  endfunction

  logic irq_wake;

  always_comb begin
    irq_wake    = masked_pending(irq_req, irq_wake_mask);
    wake_any    = irq_wake || wake_rst;
    wake_by_rst = wake_rst;   // reset has priority over interrupts
  end
endmodule

// File: rtl/hws_settle.sv
module hws_settle #(
  parameter int SETTLE_CYCLES = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_en,
  output logic done
);
  localparam int CNT_W = (SETTLE_CYCLES > 1) ? $clog2(SETTLE_CYCLES) : 1;
  localparam logic [CNT_W-1:0] TERM = CNT_W'(SETTLE_CYCLES - 1);

  function automatic logic at_term(input logic [CNT_W-1:0] c);
    return c == TERM;
  endfunction

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (!run_en) cnt <= '0;
    else if (!at_term(cnt)) cnt <= cnt + 1'b1;
  end

  always_comb done = run_en && at_term(cnt);

  assert_cnt_bounded_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= TERM);
  assert_cnt_fresh_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_en) |-> cnt == '0);
endmodule

// File: rtl/halt_wake_seq.sv
module halt_wake_seq
  import hws_pkg::*;
#(
  parameter int NUM_IRQ       = 8,
  parameter int SETTLE_CYCLES = 256
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               halt_req,
  input  logic               active_halt_en,
  input  logic               wdg_en,
  input  logic               wdg_halt_opt,
  input  logic [NUM_IRQ-1:0] irq_req,
  input  logic [NUM_IRQ-1:0] irq_wake_mask,
  input  logic               wake_rst,
  output logic               osc_en,
  output logic               cpu_clk_en,
  output logic               imask_clr,
  output logic               wdg_rst_req,
  output logic               resume_stb,
  output logic               resume_rst
);
  hws_state_e state, state_nx;
  logic halt_go, wdg_trip, wake_any, wake_by_rst, settle_done;
  logic in_run, in_halt, in_settle;
  logic imask_q, resume_q, tag_q;

  always_comb begin
    in_run    = (state == ST_RUN);
    in_halt   = (state == ST_HALT);
    in_settle = (state == ST_SETTLE);
  end

  hws_entry u_entry (
    .in_run(in_run), .halt_req(halt_req), .active_halt_en(active_halt_en),
    .wdg_en(wdg_en), .wdg_halt_opt(wdg_halt_opt),
    .halt_go(halt_go), .wdg_trip(wdg_trip)
  );

  hws_wake #(.NUM_IRQ(NUM_IRQ)) u_wake (
    .irq_req(irq_req), .irq_wake_mask(irq_wake_mask), .wake_rst(wake_rst),
    .wake_any(wake_any), .wake_by_rst(wake_by_rst)
  );

  hws_settle #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_settle (
    .clk(clk), .rst_n(rst_n), .run_en(in_settle), .done(settle_done)
  );

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_RUN:    if (halt_go) state_nx = ST_HALT;
                 else if (wdg_trip) state_nx = ST_WDGRST;
      ST_HALT:   if (wake_any) state_nx = ST_SETTLE;
      ST_SETTLE: if (settle_done) state_nx = ST_RUN;
      ST_WDGRST: state_nx = ST_RUN;
      default:   state_nx = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_RUN;
      imask_q  <= 1'b0;
      resume_q <= 1'b0;
      tag_q    <= 1'b0;
    end else begin
      state    <= state_nx;
      imask_q  <= halt_go;
      resume_q <= in_settle && settle_done;
      if (in_halt && wake_any) tag_q <= wake_by_rst;
    end
  end

  always_comb begin
    osc_en      = !in_halt;
    cpu_clk_en  = in_run;
    imask_clr   = imask_q;
    wdg_rst_req = (state == ST_WDGRST);
    resume_stb  = resume_q;
    resume_rst  = tag_q;
  end

  // Assertions next to the logic they guard
  assert_ah_ignored_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_run && halt_req && active_halt_en) |=> (cpu_clk_en && osc_en && !imask_clr && !wdg_rst_req));
  assert_wdg_trip_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_run && halt_req && !active_halt_en && wdg_en && !wdg_halt_opt) |=> (wdg_rst_req && osc_en));
  assert_wdg_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wdg_rst_req |=> (!wdg_rst_req && cpu_clk_en));
  assert_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_run && halt_req && !active_halt_en && (!wdg_en || wdg_halt_opt)) |=> (!osc_en && imask_clr));
  assert_imask_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    imask_clr |=> !imask_clr);
  assert_masked_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!osc_en && ((irq_req & irq_wake_mask) == '0) && !wake_rst) |=> !osc_en);
  assert_wake_osc_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(osc_en) |-> !cpu_clk_en);
  assert_resume_R7: assert property (@(posedge clk) disable iff (!rst_n)
    resume_stb |-> (cpu_clk_en && !$past(cpu_clk_en)));
  assert_rst_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!osc_en && wake_rst) |=> resume_rst);
endmodule

// File: tb/halt_wake_seq_tb.sv
`timescale 1ns/1ps
module halt_wake_seq_tb;
  localparam int NI = 8;
  localparam int SC = 256;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic halt_req = 0, active_halt_en = 0, wdg_en = 0, wdg_halt_opt = 0, wake_rst = 0;
  logic [NI-1:0] irq_req = '0, irq_wake_mask = '0;
  logic osc_en, cpu_clk_en, imask_clr, wdg_rst_req, resume_stb, resume_rst;

  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  halt_wake_seq #(.NUM_IRQ(NI), .SETTLE_CYCLES(SC)) u_dut (
    .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .active_halt_en(active_halt_en),
    .wdg_en(wdg_en), .wdg_halt_opt(wdg_halt_opt), .irq_req(irq_req),
    .irq_wake_mask(irq_wake_mask), .wake_rst(wake_rst), .osc_en(osc_en),
    .cpu_clk_en(cpu_clk_en), .imask_clr(imask_clr), .wdg_rst_req(wdg_rst_req),
    .resume_stb(resume_stb), .resume_rst(resume_rst)
  );

  // {halt, active_halt, wdg_en, wdg_opt} irq mask {osc, clk, imask_clr, wdg_rst}
  localparam logic [23:0] VEC [0:5] = '{
    24'h00000C, 24'hC0000C, 24'hA00009, 24'hB00002, 24'h800002, 24'hE0000C
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    halt_req = 0; active_halt_en = 0; wdg_en = 0; wdg_halt_opt = 0;
    wake_rst = 0; irq_req = '0; irq_wake_mask = '0;
    rst_n = 0;
    tick(); tick();
    rst_n = 1;
    tick();
  endtask

  task automatic enter_halt();
    halt_req = 1;
    tick();
    halt_req = 0;
  endtask

  // called right after the wake tick; counts gated cycles until resume
  task automatic settle_and_resume(input string req, input int exp_tag);
    int n = 0;
    bit osc_ok = 1;
    while (!cpu_clk_en && n < 1000) begin
      if (!osc_en) osc_ok = 0;
      n++;
      tick();
    end
    chk("R6", "gated cycles", n, SC);
    chk("R6", "osc on during settle", osc_ok, 1);
    chk("R7", "resume strobe", resume_stb, 1);
    chk(req, "resume tag", resume_rst, exp_tag);
    tick();
    chk("R7", "strobe one cycle", resume_stb, 0);
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    string tag;
    do_reset();
    // R9 reset state
    chk("R9", "osc_en", osc_en, 1);
    chk("R9", "cpu_clk_en", cpu_clk_en, 1);
    chk("R9", "imask_clr", imask_clr, 0);
    chk("R9", "wdg_rst_req", wdg_rst_req, 0);
    chk("R9", "resume_stb", resume_stb, 0);

    // vector table: one decision from the running state
    for (int i = 0; i < 6; i++) begin
      do_reset();
      {halt_req, active_halt_en, wdg_en, wdg_halt_opt} = VEC[i][23:20];
      irq_req = VEC[i][19:12];
      irq_wake_mask = VEC[i][11:4];
      tick();
      halt_req = 0;
      case (i)
        1, 5:    tag = "R1";
        2:       tag = "R2";
        3, 4:    tag = "R3";
        default: tag = "R9";
      endcase
      chk(tag, "osc_en", osc_en, int'(VEC[i][3]));
      chk(tag, "cpu_clk_en", cpu_clk_en, int'(VEC[i][2]));
      chk(tag, "imask_clr", imask_clr, int'(VEC[i][1]));
      chk(tag, "wdg_rst_req", wdg_rst_req, int'(VEC[i][0]));
    end

    // R2: watchdog request lasts one cycle, then running again
    do_reset();
    wdg_en = 1; wdg_halt_opt = 0;
    enter_halt();
    chk("R2", "wdg_rst_req first", wdg_rst_req, 1);
    tick();
    chk("R2", "wdg_rst_req second", wdg_rst_req, 0);
    chk("R2", "running after trip", cpu_clk_en, 1);

    // R3 + R4 + R6 + R7: halt, masked lines ignored, interrupt wake
    do_reset();
    irq_wake_mask = 8'hF0;
    enter_halt();
    chk("R3", "imask_clr on entry", imask_clr, 1);
    irq_req = 8'h0F;
    tick();
    chk("R3", "imask_clr one cycle", imask_clr, 0);
    for (int k = 0; k < 5; k++) begin
      tick();
      chk("R4", "osc off with masked irq", osc_en, 0);
    end
    irq_req = 8'h20;
    tick();
    irq_req = '0;
    chk("R6", "osc on after wake", osc_en, 1);
    settle_and_resume("R7", 0);

    // R5: wake-capable interrupt pending at entry
    do_reset();
    irq_wake_mask = 8'h10; irq_req = 8'h10;
    enter_halt();
    chk("R5", "halted one cycle", osc_en, 0);
    tick();
    irq_req = '0;
    chk("R5", "osc back on", osc_en, 1);
    settle_and_resume("R5", 0);

    // R8: reset wake
    do_reset();
    enter_halt();
    tick();
    wake_rst = 1;
    tick();
    wake_rst = 0;
    settle_and_resume("R8", 1);

    // R8: simultaneous reset and interrupt wake
    do_reset();
    irq_wake_mask = 8'h01;
    enter_halt();
    tick();
    irq_req = 8'h01; wake_rst = 1;
    tick();
    irq_req = '0; wake_rst = 0;
    settle_and_resume("R8", 1);

    // R8 then interrupt: tag returns to interrupt service
    irq_wake_mask = 8'h02;
    enter_halt();
    irq_req = 8'h02;
    tick();
    irq_req = '0;
    settle_and_resume("R8", 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule